// File: doc/BRIEF.md
# Fragment DMA Engine with Deferred Completion Word

This block moves one stored event fragment from a shared buffer memory to a host address each time a descriptor is offered to it. A descriptor names where the fragment starts in the buffer, how many 32-bit words it holds, and the host byte address it must be written to. The engine reads the fragment one word at a time through the buffer arbiter port. It stages the words in a small data FIFO and sends them out as bursts on a simple host-write port.

The first word of the fragment is held back in a register. Words 1 to N-1 go to the host first, at the target address plus 4 and upward. Once every one of those bursts has been acknowledged, the held word is written at the target base address. Host software polls that location, so a changed value there means the whole fragment has arrived. The engine works on one descriptor at a time and accepts the next one only after the completion word has been acknowledged.

Top module: `frag_dma_engine`

## Requirements
- R1: After reset, busy_o is 0, desc_ready_o is 1, and rd_req_o and wr_valid_o are 0.
- R2: A descriptor is taken on a cycle where desc_valid_i and desc_ready_o are both 1, and busy_o rises on the next cycle. While busy_o is 1, desc_ready_o stays 0, so a descriptor held on the inputs during a transfer is not taken.
- R3: For a descriptor (buffer word address B, length N, host byte address H), fragment word k for k = 1..N-1 is written with data equal to buffer word (B+k) mod 2^16 at host address H+4k.
- R4: Fragment word 0 is written exactly once, as the last write of the transfer, at address H, with wr_last_o = 1.
- R5: The write of word 0 is issued only after every earlier burst has received its wr_ack_i pulse.
- R6: Words 1..N-1 are sent in ascending address order, in bursts of at most 16 beats. wr_last_o is 1 on the 16th beat of a burst and on word N-1, and 0 on every other body beat. Each burst is acknowledged by one wr_ack_i pulse.
- R7: With N = 1, the only write is word 0 at address H.
- R8: While wr_valid_o = 1 and wr_ready_i = 0, on the next cycle wr_valid_o stays 1 and wr_addr_o, wr_data_o and wr_last_o are unchanged.
- R9: busy_o stays 1 until the wr_ack_i pulse for the word-0 write, and falls on the following cycle, when desc_ready_o returns to 1.
- R10: Buffer reads are issued for addresses B, B+1, ..., B+N-1 (mod 2^16), in that order, one outstanding at a time. rd_addr_o is held stable while rd_req_o = 1 and rd_gnt_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_valid_i | input | 1 | Descriptor FIFO not empty |
| desc_ready_o | output | 1 | Pop of the descriptor FIFO (engine idle) |
| desc_buf_addr_i | input | 16 | Buffer start word address |
| desc_len_i | input | 16 | Fragment length in words, at least 1 |
| desc_host_addr_i | input | 32 | Host target byte address |
| busy_o | output | 1 | Transfer in progress |
| rd_req_o | output | 1 | Buffer read request to the arbiter |
| rd_addr_o | output | 16 | Buffer read word address |
| rd_gnt_i | input | 1 | Arbiter accepts the request |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Host write beat valid |
| wr_ready_i | input | 1 | Host accepts the beat |
| wr_addr_o | output | 32 | Host write byte address |
| wr_data_o | output | 32 | Host write data |
| wr_last_o | output | 1 | Final beat of a burst |
| wr_ack_i | input | 1 | One pulse per completed burst |

## Verification
The assertions take some things for granted about the inputs. Descriptor lengths are never zero. The arbiter returns exactly one rd_valid_i for each granted read, and only after the grant. wr_ack_i never pulses when no burst is waiting for acknowledgement. The bench models the arbiter and the host so that these hold by construction. It returns read data one cycle after each grant and keeps a count of bursts awaiting acknowledgement, pulsing wr_ack_i only while that count is non-zero. Grant, ready and acknowledge patterns vary from one run to the next.

// File: rtl/frag_dma_pkg.sv
package frag_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BODY,
    ST_HEAD,
    ST_HWAIT
  } dma_state_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/frag_dma_rd_seq.sv
module frag_dma_rd_seq #(
  parameter int unsigned BAW = 16,
  parameter int unsigned LW  = 16,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [BAW-1:0] base_i,
  input  logic [LW-1:0]  len_i,
  input  logic           fifo_full_i,
  output logic           rd_req_o,
  output logic [BAW-1:0] rd_addr_o,
  input  logic           rd_gnt_i,
  input  logic           rd_valid_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           push_o,
  output logic [DW-1:0]  push_data_o,
  output logic [DW-1:0]  head_o,
  output logic           done_o
);
  logic [BAW-1:0] addr_q;
  logic [LW-1:0]  len_q, issued_q, recv_q;
  logic           req_q, pend_q;
  logic [DW-1:0]  head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      len_q    <= '0;
      issued_q <= '0;
      recv_q   <= '0;
      req_q    <= 1'b0;
      pend_q   <= 1'b0;
      head_q   <= '0;
    end else if (start_i) begin
      addr_q   <= base_i;
      len_q    <= len_i;
      issued_q <= '0;
      recv_q   <= '0;
      req_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (req_q && rd_gnt_i) begin
        req_q    <= 1'b0;
        pend_q   <= 1'b1;
        addr_q   <= addr_q + BAW'(1);
        issued_q <= issued_q + LW'(1);
      end else if (pend_q && rd_valid_i) begin
        pend_q <= 1'b0;
        recv_q <= recv_q + LW'(1);
        if (recv_q == '0) head_q <= rd_data_i;
      end else if (!req_q && !pend_q && issued_q != len_q && !fifo_full_i) begin
        // one outstanding read; room in the FIFO is reserved when issuing
        req_q <= 1'b1;
      end
    end
  end

  assign rd_req_o    = req_q;
  assign rd_addr_o   = addr_q;
  assign push_o      = pend_q && rd_valid_i && (recv_q != '0);
  assign push_data_o = rd_data_i;
  assign head_o      = head_q;
  assign done_o      = (recv_q == len_q) && !pend_q;
endmodule

// File: rtl/frag_dma_fifo.sv
module frag_dma_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= push_data_i;
  end

  assign pop_data_o = mem_q[rp_q];
  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/frag_dma_wr_burst.sv
module frag_dma_wr_burst #(
  parameter int unsigned HAW   = 32,
  parameter int unsigned LW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned BURST = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [HAW-1:0] base_i,
  input  logic [LW-1:0]  cnt_i,
  input  logic [DW-1:0]  data_i,
  input  logic           empty_i,
  output logic           pop_o,
  output logic           wr_valid_o,
  input  logic           wr_ready_i,
  output logic [HAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_last_o,
  output logic           done_o
);
  localparam int unsigned BW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [BW-1:0] BEAT_END = BW'(BURST-1);

  logic [HAW-1:0] addr_q;
  logic [LW-1:0]  left_q;
  logic [BW-1:0]  beat_q;
  logic           fire;

  assign wr_valid_o = (left_q != '0) && !empty_i;
  assign wr_last_o  = (beat_q == BEAT_END) || (left_q == LW'(1));
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_i;
  assign fire       = wr_valid_o && wr_ready_i;
  assign pop_o      = fire;
  assign done_o     = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      addr_q <= base_i;
      left_q <= cnt_i;
      beat_q <= '0;
    end else if (fire) begin
      addr_q <= addr_q + HAW'(frag_dma_pkg::WORD_BYTES);
      left_q <= left_q - LW'(1);
      beat_q <= wr_last_o ? '0 : beat_q + BW'(1);
    end
  end
endmodule

// File: rtl/frag_dma_engine.sv
module frag_dma_engine #(
  parameter int unsigned BAW        = 16,
  parameter int unsigned HAW        = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LW         = 16,
  parameter int unsigned BURST      = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned OW         = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           desc_valid_i,
  output logic           desc_ready_o,
  input  logic [BAW-1:0] desc_buf_addr_i,
  input  logic [LW-1:0]  desc_len_i,
  input  logic [HAW-1:0] desc_host_addr_i,
  output logic           busy_o,
  output logic           rd_req_o,
  output logic [BAW-1:0] rd_addr_o,
  input  logic           rd_gnt_i,
  input  logic           rd_valid_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           wr_valid_o,
  input  logic           wr_ready_i,
  output logic [HAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_last_o,
  input  logic           wr_ack_i
);
  import frag_dma_pkg::*;

  dma_state_e     state_q;
  logic [HAW-1:0] host_q;
  logic [OW-1:0]  outst_q;
  logic           start;

  logic          push, pop, f_empty, f_full, rd_done, bw_done;
  logic [DW-1:0] push_data, pop_data, head;
  logic          bw_valid, bw_last, bw_ready;
  logic [HAW-1:0] bw_addr;
  logic [DW-1:0]  bw_data;

  assign start        = desc_valid_i && (state_q == ST_IDLE);
  assign desc_ready_o = (state_q == ST_IDLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign bw_ready     = wr_ready_i && (state_q == ST_BODY);

  frag_dma_rd_seq #(.BAW(BAW), .LW(LW), .DW(DW)) u_rd (
    .clk_i, .rst_ni,
    .start_i     (start),
    .base_i      (desc_buf_addr_i),
    .len_i       (desc_len_i),
    .fifo_full_i (f_full),
    .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_valid_i, .rd_data_i,
    .push_o      (push),
    .push_data_o (push_data),
    .head_o      (head),
    .done_o      (rd_done)
  );

  frag_dma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i       (start),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .pop_data_o  (pop_data),
    .empty_o     (f_empty),
    .full_o      (f_full)
  );

  frag_dma_wr_burst #(.HAW(HAW), .LW(LW), .DW(DW), .BURST(BURST)) u_wr (
    .clk_i, .rst_ni,
    .start_i    (start),
    .base_i     (desc_host_addr_i + HAW'(WORD_BYTES)),
    .cnt_i      (desc_len_i - LW'(1)),
    .data_i     (pop_data),
    .empty_i    (f_empty),
    .pop_o      (pop),
    .wr_valid_o (bw_valid),
    .wr_ready_i (bw_ready),
    .wr_addr_o  (bw_addr),
    .wr_data_o  (bw_data),
    .wr_last_o  (bw_last),
    .done_o     (bw_done)
  );

  // completion word replaces the burst path once the body is retired
  always_comb begin
    if (state_q == ST_HEAD) begin
      wr_valid_o = 1'b1;
      wr_addr_o  = host_q;
      wr_data_o  = head;
      wr_last_o  = 1'b1;
    end else begin
      wr_valid_o = bw_valid && (state_q == ST_BODY);
      wr_addr_o  = bw_addr;
      wr_data_o  = bw_data;
      wr_last_o  = bw_last;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= '0;
    end else begin
      outst_q <= outst_q + OW'(wr_valid_o && wr_ready_i && wr_last_o)
                         - OW'(wr_ack_i && outst_q != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      host_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_BODY;
          host_q  <= desc_host_addr_i;
        end
        ST_BODY:  if (rd_done && bw_done && outst_q == '0) state_q <= ST_HEAD;
        ST_HEAD:  if (wr_ready_i) state_q <= ST_HWAIT;
        ST_HWAIT: if (wr_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frag_dma_engine_chk.sv
module frag_dma_engine_chk #(
  parameter int unsigned BAW   = 16,
  parameter int unsigned HAW   = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned BURST = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           desc_valid_i,
  input logic           desc_ready_o,
  input logic [HAW-1:0] desc_host_addr_i,
  input logic           busy_o,
  input logic           rd_req_o,
  input logic [BAW-1:0] rd_addr_o,
  input logic           rd_gnt_i,
  input logic           wr_valid_o,
  input logic           wr_ready_i,
  input logic [HAW-1:0] wr_addr_o,
  input logic [DW-1:0]  wr_data_o,
  input logic           wr_last_o,
  input logic           wr_ack_i
);
  localparam logic [7:0] BEAT_MAX = 8'(BURST-1);

  logic [HAW-1:0] base_q;
  logic [7:0]     out_c, beat_c;
  logic           beat_fire, head_wr;

  assign beat_fire = wr_valid_o && wr_ready_i;
  assign head_wr   = busy_o && wr_valid_o && (wr_addr_o == base_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      out_c  <= '0;
      beat_c <= '0;
    end else begin
      if (desc_valid_i && desc_ready_o) base_q <= desc_host_addr_i;
      out_c <= out_c + 8'(beat_fire && wr_last_o) - 8'(wr_ack_i && out_c != '0);
      if (beat_fire) beat_c <= wr_last_o ? '0 : beat_c + 8'd1;
    end
  end

  // R2
  desc_take_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_i && desc_ready_o) |=> (busy_o && !desc_ready_o));

  // R4
  head_is_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_wr |-> wr_last_o);

  // R5
  head_after_acks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_wr |-> (out_c == '0));

  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_fire && beat_c == BEAT_MAX) |-> wr_last_o);

  // R8
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_last_o)));

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(wr_ack_i) && desc_ready_o));

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

bind frag_dma_engine frag_dma_engine_chk #(
  .BAW(BAW), .HAW(HAW), .DW(DW), .BURST(BURST)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .desc_valid_i     (desc_valid_i),
  .desc_ready_o     (desc_ready_o),
  .desc_host_addr_i (desc_host_addr_i),
  .busy_o           (busy_o),
  .rd_req_o         (rd_req_o),
  .rd_addr_o        (rd_addr_o),
  .rd_gnt_i         (rd_gnt_i),
  .wr_valid_o       (wr_valid_o),
  .wr_ready_i       (wr_ready_i),
  .wr_addr_o        (wr_addr_o),
  .wr_data_o        (wr_data_o),
  .wr_last_o        (wr_last_o),
  .wr_ack_i         (wr_ack_i)
);

// File: tb/frag_dma_engine_tb_top.sv
`timescale 1ns/1ps
module frag_dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        desc_valid_i = 1'b0, desc_ready_o;
  logic [15:0] desc_buf_addr_i = '0, desc_len_i = '0;
  logic [31:0] desc_host_addr_i = '0;
  logic        busy_o, rd_req_o, rd_gnt_i = 1'b0, rd_valid_i = 1'b0;
  logic [15:0] rd_addr_o;
  logic [31:0] rd_data_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b0, wr_last_o, wr_ack_i = 1'b0;
  logic [31:0] wr_addr_o, wr_data_o;

  frag_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i, .desc_ready_o, .desc_buf_addr_i, .desc_len_i, .desc_host_addr_i,
    .busy_o, .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_valid_i, .rd_data_i,
    .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o, .wr_last_o, .wr_ack_i
  );

  localparam int NV = 9;
  localparam logic [15:0] V_BUF  [NV] = '{16'h0010, 16'h0100, 16'h0200, 16'h0300, 16'h0050,
                                         16'h0400, 16'hFFF0, 16'h0800, 16'h0900};
  localparam logic [15:0] V_LEN  [NV] = '{16'd5, 16'd17, 16'd18, 16'd40, 16'd2,
                                         16'd33, 16'd20, 16'd100, 16'd24};
  localparam logic [31:0] V_HOST [NV] = '{32'h1000_0000, 32'h2000_0040, 32'h3000_0100, 32'h0000_8000,
                                         32'h4000_0004, 32'h5000_0000, 32'h6000_0010, 32'h7000_0000,
                                         32'h8000_0200};
  localparam int V_MODE  [NV] = '{0, 1, 2, 0, 1, 2, 1, 0, 3};
  localparam int V_BURST [NV] = '{1, 1, 2, 3, 1, 2, 2, 7, 2};

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [31:0] mem_word(logic [15:0] a);
    return {a ^ 16'h5a3c, a + 16'h1234};
  endfunction

  logic [15:0] s_buf = '0, s_len = '0;
  logic [31:0] s_host = '0;
  int s_mode = 0, phase = 0;
  bit start_req = 0, done_flag = 0;

  logic [31:0] wl_addr [256], wl_data [256];
  bit          wl_last [256];
  logic [15:0] rl_addr [256];
  int wl_n = 0, rl_n = 0, acks_tot = 0, acks_at_final = -1, accepts = 0;
  int stab_err = 0, pend_acks = 0;
  bit rv_pend = 0, pv_valid = 0, pv_ready = 0;
  logic [15:0] rv_addr = '0;
  logic [31:0] pv_addr = '0, pv_data = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // inputs driven at negedge; handshakes logged as (outputs now) & (inputs just set)
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pv_valid && !pv_ready)
      if (!wr_valid_o || wr_addr_o != pv_addr || wr_data_o != pv_data) stab_err++;
    rd_valid_i = rv_pend;
    if (rv_pend) rd_data_i = mem_word(rv_addr);
    rv_pend = 0;
    rd_gnt_i = (cyc % 3) != 1;
    case (s_mode)
      0: wr_ready_i = 1'b1;
      1: wr_ready_i = cyc[0];
      2: wr_ready_i = (cyc % 4) == 0;
      default: wr_ready_i = (cyc % 16) >= 12;
    endcase
    wr_ack_i = 1'b0;
    if (pend_acks > 0 && (cyc % 3) == 0) begin
      wr_ack_i = 1'b1;
      pend_acks--;
    end
    case (phase)
      0: if (start_req) begin
        start_req = 0;
        desc_valid_i = 1'b1;
        desc_buf_addr_i = s_buf;
        desc_len_i = s_len;
        desc_host_addr_i = s_host;
        phase = 1;
      end
      2: begin
        desc_buf_addr_i = 16'hdead;
        desc_len_i = 16'd3;
        desc_host_addr_i = 32'hbad0_0000;
        if (desc_ready_o) begin
          desc_valid_i = 1'b0;
          phase = 0;
          done_flag = 1;
        end else desc_valid_i = 1'b1;
      end
      default: ;
    endcase
    if (desc_valid_i && desc_ready_o) begin
      accepts++;
      if (phase == 1) phase = 2;
    end
    if (rd_req_o && rd_gnt_i) begin
      rv_pend = 1;
      rv_addr = rd_addr_o;
      if (rl_n < 256) rl_addr[rl_n] = rd_addr_o;
      rl_n++;
    end
    if (wr_valid_o && wr_ready_i) begin
      if (wr_addr_o == s_host) acks_at_final = acks_tot;
      if (wl_n < 256) begin
        wl_addr[wl_n] = wr_addr_o;
        wl_data[wl_n] = wr_data_o;
        wl_last[wl_n] = wr_last_o;
      end
      wl_n++;
      if (wr_last_o) pend_acks++;
    end
    if (wr_ack_i) acks_tot++;
    pv_valid = wr_valid_o;
    pv_ready = wr_ready_i;
    pv_addr = wr_addr_o;
    pv_data = wr_data_o;
  end

  task automatic run_desc(logic [15:0] b, logic [15:0] n, logic [31:0] h, int mode, int exp_b);
    int rbad = 0, wbad = 0, lbad = 0, nlast = 0;
    wl_n = 0; rl_n = 0; acks_tot = 0; acks_at_final = -1; accepts = 0; stab_err = 0;
    s_buf = b; s_len = n; s_host = h; s_mode = mode;
    start_req = 1;
    wait (done_flag);
    done_flag = 0;
    @(negedge clk);
    check(accepts == 1, "R2", "descriptors taken", accepts, 1);
    for (int k = 0; k < int'(n) && k < rl_n; k++)
      if (rl_addr[k] != 16'(b + 16'(k))) rbad++;
    check(rl_n == int'(n) && rbad == 0, "R10", "read order errors", rbad + (rl_n - int'(n)), 0);
    check(wl_n == int'(n), "R3", "write count", wl_n, n);
    for (int k = 1; k < int'(n) && k <= wl_n && k < 256; k++) begin
      if (wl_addr[k-1] != h + 32'(4 * k) || wl_data[k-1] != mem_word(16'(b + 16'(k)))) wbad++;
      if (wl_last[k-1] != ((k % 16) == 0 || k == int'(n) - 1)) lbad++;
      if (wl_last[k-1]) nlast++;
    end
    check(wbad == 0, "R3", "body word mismatches", wbad, 0);
    if (wl_n >= 1 && wl_n <= 256)
      check(wl_addr[wl_n-1] == h && wl_data[wl_n-1] == mem_word(b) && wl_last[wl_n-1],
            "R4", "final write data", wl_data[wl_n-1], mem_word(b));
    else check(0, "R4", "final write missing", wl_n, n);
    check(lbad == 0 && nlast == exp_b, "R6", "burst count", nlast, exp_b);
    check(acks_at_final == exp_b, "R5", "acks before word0", acks_at_final, exp_b);
    check(acks_tot == exp_b + 1 && !busy_o && desc_ready_o, "R9", "acks at release", acks_tot, exp_b + 1);
    check(stab_err == 0, "R8", "stall changes", stab_err, 0);
    if (n == 16'd1) check(wl_n == 1, "R7", "writes for single word", wl_n, 1);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual %0d expected 0", cyc);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy_o && desc_ready_o && !rd_req_o && !wr_valid_o, "R1", "reset outputs",
          {busy_o, desc_ready_o, rd_req_o, wr_valid_o}, 4'b0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !rd_req_o && !wr_valid_o, "R1", "idle after reset",
          {busy_o, rd_req_o, wr_valid_o}, 0);
    for (int i = 0; i < NV; i++) run_desc(V_BUF[i], V_LEN[i], V_HOST[i], V_MODE[i], V_BURST[i]);
    // single-word fragments, back to back, with and without stalls (R7)
    run_desc(16'h0a00, 16'd1, 32'h9000_0000, 0, 0);
    run_desc(16'h0a01, 16'd1, 32'h9000_0100, 3, 0);
    // exactly one full burst plus one word, heavy stall (R6)
    run_desc(16'h0b00, 16'd18, 32'ha000_0000, 3, 2);
    finish_up();
  end
endmodule